// File: doc/BRIEF.md
# Second-Operand Shifter with Rotate Modes

This block conditions the second operand of a simple ALU datapath. It accepts a data word, a shift kind, a shift amount and the current carry flag. It returns the shifted word and a carry-out for the flag logic. It offers three shifts (left logical, right logical, right arithmetic) and two rotates: a plain right rotate, and a one-place right rotate that passes through the carry flag. A left rotate is not a separate kind. The caller requests a right rotate by (32 - k) mod 32 instead.

The datapath is a cascade of log2(DW) stages. Each stage is a row of 2-to-1 multiplexers, and one bit of the shift amount drives it, with distances 1, 2, 4 and upwards. Right shifts and rotates pass straight through the cascade. For a left shift, the word is bit-reversed before the cascade and again after it. A guard bit travels with the word through the stages and holds the last bit shifted out, and this bit becomes the carry-out. With the parameter OUT_REG set, the result and carry are captured in an output register that a synchronous active-high reset clears.

Top module: `shf_operand`

## Requirements
- R1: Kind code 0 shifts left by n and fills the low bits with zeros. For n in 1..31 the carry-out is data bit (32 - n).
- R2: Kind code 1 shifts right by n and fills the vacated high bits with zeros. For n in 1..31 the carry-out is data bit (n - 1).
- R3: Kind code 2 shifts right by n and fills the vacated high bits with copies of data bit 31. For n in 1..31 the carry-out is data bit (n - 1).
- R4: Kind code 3 rotates right by n, so bits leaving position 0 re-enter at position 31. For n in 1..31 the carry-out is data bit (n - 1). A right rotate by (32 - k) mod 32 equals a left rotate by k.
- R5: Kind code 4 ignores the amount and returns {carry_in, data[31:1]}, with data bit 0 as the carry-out.
- R6: For kind codes 0 to 3 with an amount of zero, the data passes through unchanged and the carry-out equals the carry input.
- R7: Kind codes 5, 6 and 7 pass the data through unchanged and return the carry input as the carry-out, whatever the amount.
- R8: With OUT_REG = 1, the result and carry appear one clock after their inputs. While the synchronous active-high reset is asserted, both read zero.
- R9: A word plus the same word shifted left by 3 equals nine times the word, modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | DW | Operand word to shift |
| in_kind | input | 3 | Shift kind code (0..4 defined, 5..7 pass-through) |
| in_amt | input | AW | Shift amount, AW = log2(DW) |
| in_carry | input | 1 | Current carry flag |
| out_data | output | DW | Shifted word |
| out_carry | output | 1 | Shifter carry-out |

## Verification
The assertions assume that DW is 32, that OUT_REG is set, and that the inputs are stable and known in every cycle outside reset, because each property compares one cycle's inputs with the next cycle's outputs. The stimulus changes the inputs only on falling clock edges. It covers every kind code with all 32 amounts and with fixed data corners (sign bit alone, all ones, bit 0 alone) as well as random words. Both carry-in values are used, so the amount-zero and pass-through carry checks are meaningful.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [2:0] {
    SK_LSL = 3'd0,
    SK_LSR = 3'd1,
    SK_ASR = 3'd2,
    SK_ROR = 3'd3,
    SK_RRX = 3'd4
  } shift_kind_e;
endpackage

// File: rtl/shf_bitrev.sv
module shf_bitrev #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] din,
  input  logic          en,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] flipped;

  for (genvar i = 0; i < DW; i++) begin : g_flip
    assign flipped[i] = din[DW-1-i];
  end

  assign dout = en ? flipped : din;
endmodule

// File: rtl/shf_stage.sv
// One row of 2:1 muxes: moves the word right by DIST when sel is high.
module shf_stage #(
  parameter int DW   = 32,
  parameter int DIST = 1
) (
  input  logic [DW-1:0] din,
  input  logic          gin,
  input  logic          sel,
  input  logic          rot,
  input  logic          fill,
  output logic [DW-1:0] dout,
  output logic          gout
);
  logic [DIST-1:0] top_bits;

  always_comb begin
    if (rot) top_bits = din[DIST-1:0];
    else     top_bits = {DIST{fill}};
  end

  assign dout = sel ? {top_bits, din[DW-1:DIST]} : din;
  // guard bit keeps the last bit that left position 0
  assign gout = sel ? din[DIST-1] : gin;
endmodule

// File: rtl/shf_core.sv
module shf_core
  import shf_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = $clog2(DW)
) (
  input  logic [DW-1:0] data,
  input  logic [2:0]    kind,
  input  logic [AW-1:0] amt,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          cout
);
  localparam int NSTG = AW;

  shift_kind_e   k;
  logic          is_left;
  logic          rot;
  logic          fill;
  logic [AW-1:0] eff_amt;
  logic [DW-1:0] pre;
  logic [NSTG:0][DW-1:0] w;
  logic [NSTG:0]         g;

  always_comb begin
    k       = shift_kind_e'(kind);
    is_left = (k == SK_LSL);
    rot     = (k == SK_ROR);
    fill    = 1'b0;
    eff_amt = amt;
    case (k)
      SK_ASR:  fill = data[DW-1];
      SK_RRX: begin
        fill    = cin;
        eff_amt = AW'(1);
      end
      SK_LSL, SK_LSR, SK_ROR: ;
      default: eff_amt = '0;
    endcase
  end

  shf_bitrev #(.DW(DW)) u_rev_in (
    .din (data),
    .en  (is_left),
    .dout(pre)
  );

  assign w[0] = pre;
  assign g[0] = cin;

  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    shf_stage #(.DW(DW), .DIST(1 << s)) u_stage (
      .din (w[s]),
      .gin (g[s]),
      .sel (eff_amt[s]),
      .rot (rot),
      .fill(fill),
      .dout(w[s+1]),
      .gout(g[s+1])
    );
  end

  shf_bitrev #(.DW(DW)) u_rev_out (
    .din (w[NSTG]),
    .en  (is_left),
    .dout(res)
  );

  assign cout = g[NSTG];
endmodule

// File: rtl/shf_operand.sv
module shf_operand #(
  parameter int DW      = 32,
  parameter int AW      = $clog2(DW),
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] in_data,
  input  logic [2:0]    in_kind,
  input  logic [AW-1:0] in_amt,
  input  logic          in_carry,
  output logic [DW-1:0] out_data,
  output logic          out_carry
);
  logic [DW-1:0] c_data;
  logic          c_carry;

  shf_core #(.DW(DW), .AW(AW)) u_core (
    .data(in_data),
    .kind(in_kind),
    .amt (in_amt),
    .cin (in_carry),
    .res (c_data),
    .cout(c_carry)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_data  <= '0;
        out_carry <= 1'b0;
      end else begin
        out_data  <= c_data;
        out_carry <= c_carry;
      end
    end
  end else begin : g_comb
    assign out_data  = c_data;
    assign out_carry = c_carry;
  end
endmodule

// File: rtl/shf_operand_chk.sv
module shf_operand_chk
  import shf_pkg::*;
#(
  parameter int DW      = 32,
  parameter int AW      = $clog2(DW),
  parameter bit OUT_REG = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] in_data,
  input logic [2:0]    in_kind,
  input logic [AW-1:0] in_amt,
  input logic          in_carry,
  input logic [DW-1:0] out_data,
  input logic          out_carry
);
  if (OUT_REG) begin : g_seq
    // R8
    reset_clear_chk: assert property (@(posedge clk)
      rst |=> (out_data == '0 && out_carry == 1'b0));

    // R6
    zero_amt_pass_chk: assert property (@(posedge clk) disable iff (rst)
      (in_amt == '0 && in_kind < 3'd4) |=>
        (out_data == $past(in_data) && out_carry == $past(in_carry)));

    // R7
    spare_kind_pass_chk: assert property (@(posedge clk) disable iff (rst)
      (in_kind > 3'd4) |=>
        (out_data == $past(in_data) && out_carry == $past(in_carry)));

    // R5
    rrx_shape_chk: assert property (@(posedge clk) disable iff (rst)
      (in_kind == SK_RRX) |=>
        (out_data[DW-1] == $past(in_carry) && out_carry == $past(in_data[0])));

    // R2
    lsr_top_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (in_kind == SK_LSR && in_amt != '0) |=>
        (out_data[DW-1] == 1'b0 && out_carry == $past(in_data[in_amt - AW'(1)])));

    // R3
    asr_sign_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (in_kind == SK_ASR) |=> (out_data[DW-1] == $past(in_data[DW-1])));

    // R4
    ror_ones_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (in_kind == SK_ROR) |=> ($countones(out_data) == $countones($past(in_data))));

    // R1
    lsl_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (in_kind == SK_LSL && in_amt != '0) |=> (out_data[0] == 1'b0));
  end
endmodule

bind shf_operand shf_operand_chk #(.DW(DW), .AW(AW), .OUT_REG(OUT_REG)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .in_data  (in_data),
  .in_kind  (in_kind),
  .in_amt   (in_amt),
  .in_carry (in_carry),
  .out_data (out_data),
  .out_carry(out_carry)
);

// File: tb/test_shf_operand.sv
module test_shf_operand;
  typedef struct {
    logic [31:0] d;
    logic        c;
    bit          chk_c;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] in_data = '0;
  logic [2:0]  in_kind = '0;
  logic [4:0]  in_amt = '0;
  logic        in_carry = 1'b0;
  logic [31:0] out_data;
  logic        out_carry;

  int   n_chk = 0;
  int   n_fail = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  shf_operand #(.DW(32), .OUT_REG(1'b1)) i_shf_operand (
    .clk(clk), .rst(rst), .in_data(in_data), .in_kind(in_kind),
    .in_amt(in_amt), .in_carry(in_carry),
    .out_data(out_data), .out_carry(out_carry)
  );

  function automatic exp_t ref_model(logic [31:0] d, int kind, int n, logic ci);
    exp_t e;
    e.chk_c = 1'b1;
    e.d = d;
    e.c = ci;
    if (kind > 4) begin
      e.tag = "R7";
    end else if (kind == 4) begin
      e.d = {ci, d[31:1]};
      e.c = d[0];
      e.tag = "R5";
    end else if (n == 0) begin
      e.tag = "R6";
    end else begin
      case (kind)
        0: begin e.d = d << n; e.c = d[32-n]; e.tag = "R1"; end
        1: begin e.d = d >> n; e.c = d[n-1]; e.tag = "R2"; end
        2: begin e.d = 32'($signed(d) >>> n); e.c = d[n-1]; e.tag = "R3"; end
        default: begin e.d = (d >> n) | (d << (32 - n)); e.c = d[n-1]; e.tag = "R4"; end
      endcase
    end
    return e;
  endfunction

  task automatic compare(exp_t e);
    n_chk++;
    if (out_data !== e.d || (e.chk_c && out_carry !== e.c)) begin
      n_fail++;
      $display("FAIL %s: got data=%08h carry=%b, want data=%08h carry=%b",
               e.tag, out_data, out_carry, e.d, e.c);
    end
  endtask

  task automatic apply(logic [31:0] d, int kind, int n, logic ci, exp_t e);
    @(negedge clk);
    if (q.size() > 0) compare(q.pop_front());
    in_data  = d;
    in_kind  = 3'(kind);
    in_amt   = 5'(n);
    in_carry = ci;
    q.push_back(e);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: got timeout, want finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] pats[4];
    exp_t e;
    // reset state, inputs active meanwhile (R8)
    in_data = 32'hFFFF_FFFF; in_carry = 1'b1; in_kind = 3'd4;
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_data !== '0 || out_carry !== 1'b0) begin
      n_fail++;
      $display("FAIL R8: got data=%08h carry=%b, want data=00000000 carry=0",
               out_data, out_carry);
    end
    rst = 1'b0;

    pats[0] = 32'h8000_0000;
    pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'h0000_0001;
    for (int r = 0; r < 3; r++) begin
      pats[3] = $urandom();
      for (int kind = 0; kind < 8; kind++) begin
        for (int n = 0; n < 32; n++) begin
          for (int p = 0; p < 4; p++) begin
            logic ci;
            ci = 1'((n + p + r) & 1);
            e = ref_model(pats[p], kind, n, ci);
            apply(pats[p], kind, n, ci, e);
          end
        end
      end
    end

    // R4: left rotate by k via right rotate by (32-k) mod 32
    for (int k = 0; k < 32; k++) begin
      logic [31:0] x;
      x = $urandom();
      e.d = (k == 0) ? x : ((x << k) | (x >> (32 - k)));
      e.c = 1'b0; e.chk_c = 1'b0; e.tag = "R4";
      apply(x, 3, (32 - k) % 32, 1'b0, e);
    end

    // R9: x + (x LSL 3) == 9x, so the shifted word equals 9x - x
    for (int t = 0; t < 16; t++) begin
      logic [31:0] x;
      x = $urandom();
      e.d = x * 32'd9 - x;
      e.c = 1'b0; e.chk_c = 1'b0; e.tag = "R9";
      apply(x, 0, 3, 1'b1, e);
    end

    @(negedge clk);
    if (q.size() > 0) compare(q.pop_front());

    // R8: reset reasserted clears the register
    rst = 1'b1;
    @(negedge clk);
    n_chk++;
    if (out_data !== '0 || out_carry !== 1'b0) begin
      n_fail++;
      $display("FAIL R8: got data=%08h carry=%b, want data=00000000 carry=0",
               out_data, out_carry);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule